// File: doc/BRIEF.md
# Reset Configuration Word Fetcher

This block runs straight out of power-on or hard reset, before the processor core is let go. It fetches a table of configuration bytes from the boot memory through a simple synchronous read port. Each read presents an address and a read strobe, then waits for a ready reply, and only the 8-bit top byte lane is taken. The block builds one 32-bit word for the local master and one for each of up to seven configuration slaves.

Four consecutive reads make one word, and the earliest of the four lands in the most significant byte. Reads step through memory at an 8-byte stride, so each read sits on a 64-bit boundary. Because only one byte lane is used, the width of the boot device does not matter.

When all bytes have been captured, the block releases the core's reset hold and gives a one-cycle completion pulse. It also presents the address of the first instruction fetch, which is the system-reset vector inside one of two exception bases. The prefix bit of the master word selects the base. A read that gets no reply within a set number of cycles aborts the sequence with an error flag.

Top module: `cfgword_loader`

## Requirements
- R1: While reset is asserted, `core_hold` is 1, `word_vld` is all zero, `cfg_words` is all zero, `cfg_done` and `fetch_err` are 0, and `rom_addr` is 0.
- R2: Exactly 32 reads are accepted (cycles with `rom_rd` and `rom_rdy` both high). Read n (0 to 31) uses `rom_addr` = 8*n. After the last one `rom_rd` stays low until the next reset.
- R3: While `rom_rd` is high and `rom_rdy` is low, the read is held: `rom_addr` does not change and nothing is captured. `rom_byte` is ignored in every cycle where `rom_rdy` is low.
- R4: Read 4*w+k (k = 0..3) fills bits [31-8k -: 8] of word w. Word w sits at `cfg_words[32*w +: 32]`. Word 0 is the master's word, and words 1 to 7 belong to slaves 1 to 7.
- R5: `word_vld[w]` goes high at the same clock edge that captures the fourth byte of word w, never earlier. Once set, it stays set until reset.
- R6: One clock after the edge that captures the 32nd byte, `core_hold` falls and `cfg_done` is high for exactly one cycle. `core_hold` then stays low until reset.
- R7: Once `word_vld[0]` is set, `boot_vector` is 32'hFFF00100 when bit 16 of the master word is 1, and 32'h00000100 when that bit is 0.
- R8: If `rom_rdy` stays low for 32 consecutive cycles of one read, `fetch_err` rises at the end of the 32nd cycle. After that `rom_rd` stays low, `core_hold` stays high and `cfg_done` never pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_addr | output | 32 | Byte address of the current boot-memory read |
| rom_rd | output | 1 | Read strobe, held until the read is accepted |
| rom_rdy | input | 1 | Boot memory reply: `rom_byte` is valid this cycle |
| rom_byte | input | 8 | Top byte lane of the boot-memory data bus |
| cfg_words | output | 256 | Eight assembled 32-bit words, with word w at bits [32w+31:32w] |
| word_vld | output | 8 | Per-word complete flags |
| core_hold | output | 1 | Keeps the processor core in reset while high |
| cfg_done | output | 1 | One-cycle pulse when the fetch completes |
| fetch_err | output | 1 | A read timed out and the sequence was aborted |
| boot_vector | output | 32 | Address of the first instruction fetch |

## Verification
The assertions assume that the boot memory answers only a read that is actually being strobed, and that `rom_rdy` may stay low for any number of cycles. The address-step property applies only to an accepted read that is not the last one. The reference memory in the bench answers each read after a delay that varies with the read index, from zero up to three wait cycles, and answers only while `rom_rd` is high. While `rom_rdy` is low it drives a junk byte on `rom_byte`. One run withholds the reply to a single read on purpose, to drive the sequence into the timeout path.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
   typedef enum logic [1:0] {
      ST_FETCH = 2'd0,
      ST_LAST  = 2'd1,
      ST_DONE  = 2'd2,
      ST_FAIL  = 2'd3
   } fetch_st_e;
endpackage

// File: rtl/cfgw_seq.sv
module cfgw_seq
   import cfgw_pkg::*;
#(
   parameter int NUM_READS   = 32,
   parameter int IDX_W       = 5,
   parameter int TIMEOUT_CYC = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rdy,
   output logic             rd,
   output logic [IDX_W-1:0] idx,
   output logic             cap,
   output logic             hold,
   output logic             done,
   output logic             err
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_READS - 1);

   fetch_st_e  st_q;
   logic       done_q;
   logic       expire;

   assign rd   = (st_q == ST_FETCH);
   assign cap  = rd & rdy;
   assign hold = (st_q != ST_DONE);
   assign done = done_q;
   assign err  = (st_q == ST_FAIL);

   generate
      if (TIMEOUT_CYC > 0) begin : g_timeout
         localparam int TO_W = $clog2(TIMEOUT_CYC + 1);
         logic [TO_W-1:0] wait_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        wait_q <= '0;
            else if (!rd || rdy) wait_q <= '0;
            else               wait_q <= wait_q + TO_W'(1);
         end
         assign expire = rd & ~rdy & (wait_q == TO_W'(TIMEOUT_CYC - 1));
      end else begin : g_no_timeout
         assign expire = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_FETCH;
         idx    <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_FETCH: begin
               if (cap) begin
                  if (idx == LAST_IDX) st_q <= ST_LAST;
                  else                 idx  <= idx + IDX_W'(1);
               end else if (expire) begin
                  st_q <= ST_FAIL;
               end
            end
            ST_LAST: begin
               st_q   <= ST_DONE;
               done_q <= 1'b1;
            end
            ST_DONE: st_q <= ST_DONE;
            ST_FAIL: st_q <= ST_FAIL;
            default: st_q <= ST_FAIL;
         endcase
      end
   end
endmodule

// File: rtl/cfgw_store.sv
module cfgw_store #(
   parameter int WORDS  = 8,
   parameter int BYTES  = 4,
   parameter int IDX_W  = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cap,
   input  logic [IDX_W-1:0]         idx,
   input  logic [7:0]               din,
   output logic [WORDS*BYTES*8-1:0] words,
   output logic [WORDS-1:0]         vld
);
   localparam int WORD_W = BYTES * 8;
   localparam int BSEL_W = $clog2(BYTES);
   localparam int WSEL_W = IDX_W - BSEL_W;

   logic [WSEL_W-1:0] wsel;
   logic [BSEL_W-1:0] bsel;

   assign wsel = idx[IDX_W-1:BSEL_W];
   assign bsel = idx[BSEL_W-1:0];

   generate
      for (genvar w = 0; w < WORDS; w++) begin : g_word
         logic hit;
         assign hit = cap && (wsel == WSEL_W'(w));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   vld[w] <= 1'b0;
            else if (hit && bsel == BSEL_W'(BYTES - 1))   vld[w] <= 1'b1;
         end

         for (genvar b = 0; b < BYTES; b++) begin : g_lane
            // earliest read of a group lands in the top lane
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  words[w*WORD_W + b*8 +: 8] <= 8'h00;
               else if (hit && bsel == BSEL_W'(BYTES - 1 - b))
                  words[w*WORD_W + b*8 +: 8] <= din;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cfgw_vector.sv
module cfgw_vector #(
   parameter int          WORD_W     = 32,
   parameter int          ADDR_W     = 32,
   parameter int          PREFIX_POS = 16,
   parameter logic [31:0] HI_BASE    = 32'hFFF0_0000,
   parameter logic [31:0] LO_BASE    = 32'h0000_0000,
   parameter logic [31:0] VEC_OFF    = 32'h0000_0100
) (
   input  logic [WORD_W-1:0] master_word,
   output logic [ADDR_W-1:0] vector
);
   logic [31:0] base;
   assign base   = master_word[PREFIX_POS] ? HI_BASE : LO_BASE;
   assign vector = ADDR_W'(base | VEC_OFF);
endmodule

// File: rtl/cfgword_loader.sv
module cfgword_loader #(
   parameter int ADDR_W      = 32,
   parameter int WORDS       = 8,
   parameter int BYTES       = 4,
   parameter int STRIDE      = 8,
   parameter int TIMEOUT_CYC = 32,
   parameter int PREFIX_POS  = 16,
   localparam int WORD_W     = BYTES * 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   output logic [ADDR_W-1:0]       rom_addr,
   output logic                    rom_rd,
   input  logic                    rom_rdy,
   input  logic [7:0]              rom_byte,
   output logic [WORDS*WORD_W-1:0] cfg_words,
   output logic [WORDS-1:0]        word_vld,
   output logic                    core_hold,
   output logic                    cfg_done,
   output logic                    fetch_err,
   output logic [ADDR_W-1:0]       boot_vector
);
   localparam int NUM_READS = WORDS * BYTES;
   localparam int IDX_W     = $clog2(NUM_READS);
   localparam int STRIDE_SH = $clog2(STRIDE);

   generate
      if ((1 << STRIDE_SH) != STRIDE) begin : g_bad_stride
         $error("STRIDE must be a power of two");
      end
      if (BYTES < 2 || (1 << $clog2(BYTES)) != BYTES) begin : g_bad_bytes
         $error("BYTES must be a power of two of at least 2");
      end
      if (WORDS < 1 || PREFIX_POS >= WORD_W) begin : g_bad_shape
         $error("WORDS or PREFIX_POS out of range");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   logic             cap;

   cfgw_seq #(
      .NUM_READS  (NUM_READS),
      .IDX_W      (IDX_W),
      .TIMEOUT_CYC(TIMEOUT_CYC)
   ) u_seq (
      .clk  (clk),
      .rst_n(rst_n),
      .rdy  (rom_rdy),
      .rd   (rom_rd),
      .idx  (idx),
      .cap  (cap),
      .hold (core_hold),
      .done (cfg_done),
      .err  (fetch_err)
   );

   assign rom_addr = ADDR_W'(idx) << STRIDE_SH;

   cfgw_store #(
      .WORDS(WORDS),
      .BYTES(BYTES),
      .IDX_W(IDX_W)
   ) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .cap  (cap),
      .idx  (idx),
      .din  (rom_byte),
      .words(cfg_words),
      .vld  (word_vld)
   );

   cfgw_vector #(
      .WORD_W    (WORD_W),
      .ADDR_W    (ADDR_W),
      .PREFIX_POS(PREFIX_POS)
   ) u_vec (
      .master_word(cfg_words[WORD_W-1:0]),
      .vector     (boot_vector)
   );
endmodule

// File: rtl/cfgword_loader_chk.sv
module cfgword_loader_chk #(
   parameter int ADDR_W     = 32,
   parameter int WORDS      = 8,
   parameter int BYTES      = 4,
   parameter int STRIDE     = 8,
   parameter int PREFIX_POS = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [ADDR_W-1:0]       rom_addr,
   input logic                    rom_rd,
   input logic                    rom_rdy,
   input logic [WORDS*BYTES*8-1:0] cfg_words,
   input logic [WORDS-1:0]        word_vld,
   input logic                    core_hold,
   input logic                    cfg_done,
   input logic                    fetch_err,
   input logic [ADDR_W-1:0]       boot_vector
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'((WORDS * BYTES - 1) * STRIDE);

   p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_rd && rom_rdy && rom_addr != LAST_ADDR) |=> rom_addr == $past(rom_addr) + ADDR_W'(STRIDE));

   p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_rd && !rom_rdy) |=> $stable(rom_addr) && $stable(word_vld));

   p_vld_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((word_vld & $past(word_vld)) == $past(word_vld)));

   p_vld_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(word_vld) <= $countones($past(word_vld)) + 1);

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> !cfg_done);

   p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_hold) |-> cfg_done && word_vld[WORDS-1]);

   p_hold_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !core_hold |=> !core_hold && !rom_rd);

   p_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld[0] |-> boot_vector[ADDR_W-1:20] == {(ADDR_W-20){cfg_words[PREFIX_POS]}}
                      && boot_vector[19:0] == 20'h00100);

   p_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_err |-> core_hold && !rom_rd && !cfg_done);
endmodule

bind cfgword_loader cfgword_loader_chk #(
   .ADDR_W    (ADDR_W),
   .WORDS     (WORDS),
   .BYTES     (BYTES),
   .STRIDE    (STRIDE),
   .PREFIX_POS(PREFIX_POS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rom_addr   (rom_addr),
   .rom_rd     (rom_rd),
   .rom_rdy    (rom_rdy),
   .cfg_words  (cfg_words),
   .word_vld   (word_vld),
   .core_hold  (core_hold),
   .cfg_done   (cfg_done),
   .fetch_err  (fetch_err),
   .boot_vector(boot_vector)
);

// File: tb/cfgword_loader_test.sv
module cfgword_loader_test;
   localparam int CLK_PERIOD = 10;
   localparam int TMO        = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [31:0]  rom_addr;
   logic         rom_rd;
   logic         rom_rdy = 1'b0;
   logic [7:0]   rom_byte = 8'h00;
   logic [255:0] cfg_words;
   logic [7:0]   word_vld;
   logic         core_hold, cfg_done, fetch_err;
   logic [31:0]  boot_vector;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfgword_loader uut (
      .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_rd(rom_rd),
      .rom_rdy(rom_rdy), .rom_byte(rom_byte), .cfg_words(cfg_words),
      .word_vld(word_vld), .core_hold(core_hold), .cfg_done(cfg_done),
      .fetch_err(fetch_err), .boot_vector(boot_vector)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] img [8];

   // reference model state: 0 fetching, 1 last captured, 2 done, 3 failed
   int m_st, m_idx, m_wait, lat_cnt, reads, lat_mode, stall_at;
   bit m_done;
   logic [7:0] m_vld;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int lat_of(input int n);
      case (lat_mode)
         0: return n % 4;
         1: return 0;
         default: return n % 3;
      endcase
   endfunction

   task automatic compare();
      chk(core_hold == (m_st != 2), "R6 core_hold", 32'(core_hold), 32'(m_st != 2));
      chk(cfg_done == m_done, "R6 cfg_done", 32'(cfg_done), 32'(m_done));
      chk(fetch_err == (m_st == 3), "R8 fetch_err", 32'(fetch_err), 32'(m_st == 3));
      chk(rom_rd == (m_st == 0), "R2 rom_rd", 32'(rom_rd), 32'(m_st == 0));
      if (m_st == 0) chk(rom_addr == 32'(m_idx * 8), "R3 rom_addr", rom_addr, 32'(m_idx * 8));
      chk(word_vld == m_vld, "R5 word_vld", 32'(word_vld), 32'(m_vld));
      for (int w = 0; w < 8; w++)
         if (m_vld[w]) chk(cfg_words[w*32 +: 32] == img[w], "R4 word", cfg_words[w*32 +: 32], img[w]);
      if (m_vld[0]) begin
         logic [31:0] ev;
         ev = img[0][16] ? 32'hFFF0_0100 : 32'h0000_0100;
         chk(boot_vector == ev, "R7 boot_vector", boot_vector, ev);
      end
   endtask

   task automatic drive_and_advance();
      bit go;
      go = (m_st == 0) && (m_idx != stall_at) && (lat_cnt >= lat_of(m_idx));
      rom_rdy  = go;
      rom_byte = go ? img[m_idx/4][(3 - (m_idx % 4))*8 +: 8] : 8'hEE;
      case (m_st)
         0: begin
            if (go) begin
               reads++;
               if (m_idx % 4 == 3) m_vld[m_idx/4] = 1'b1;
               lat_cnt = 0;
               m_wait  = 0;
               if (m_idx == 31) m_st = 1;
               else m_idx++;
            end else begin
               lat_cnt++;
               m_wait++;
               if (m_wait == TMO) m_st = 3;
            end
         end
         1: begin m_st = 2; m_done = 1'b1; end
         default: m_done = 1'b0;
      endcase
   endtask

   task automatic run(input int mode, input int stall);
      int post;
      lat_mode = mode; stall_at = stall;
      m_st = 0; m_idx = 0; m_wait = 0; lat_cnt = 0; reads = 0; m_done = 1'b0; m_vld = '0;
      @(negedge clk);
      rst_n = 1'b0; rom_rdy = 1'b0; rom_byte = 8'h5A;
      repeat (3) begin
         @(negedge clk);
         chk(core_hold === 1'b1, "R1 hold in reset", 32'(core_hold), 32'd1);
         chk(word_vld === 8'h00, "R1 vld in reset", 32'(word_vld), 32'd0);
         chk(cfg_words === '0, "R1 words in reset", cfg_words[31:0], 32'd0);
         chk(cfg_done === 1'b0 && fetch_err === 1'b0, "R1 flags in reset",
             32'({cfg_done, fetch_err}), 32'd0);
         chk(rom_addr === 32'd0, "R1 addr in reset", rom_addr, 32'd0);
      end
      rst_n = 1'b1;
      drive_and_advance();
      post = 0;
      while (post < 6) begin
         @(negedge clk);
         compare();
         if (m_st >= 2) post++;
         drive_and_advance();
      end
      if (stall < 0)
         chk(reads == 32, "R2 read count", 32'(reads), 32'd32);
      else
         chk(reads == stall, "R8 reads before abort", 32'(reads), 32'(stall));
   endtask

   initial begin
      for (int w = 0; w < 8; w++) img[w] = 32'hC0DE_0000 + 32'(w) * 32'h1111_1011;
      img[0] = 32'h0A5F_1234;                 // prefix bit 16 set
      run(0, -1);                             // R7 high base, varied waits (R3)
      for (int w = 0; w < 8; w++) img[w] = 32'h3C96_A50F ^ (32'(w) * 32'h0101_0303);
      img[0] = 32'h0A5E_8765;                 // prefix bit 16 clear
      run(1, -1);                             // R7 low base, zero-wait reads
      run(2, 5);                              // R8 timeout on read 5
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule